// File: doc/BRIEF.md
# Processor control and status register

This block is the 32-bit control and status word of a small processor core. Software reaches it through a move port with a read strobe, a write strobe and a 32-bit data word. The rest of the core sees its configuration on dedicated outputs: the global interrupt enable, the program and data cache modes, and the stored power-down request.

The identity fields come from constant inputs. The endian bit follows a device pin. Each functional unit reports a saturating operation on its own lane, together with the result of that instruction's condition. The block turns qualified reports into a sticky saturation flag that software can clear but never set. An interrupt-entry strobe saves the global enable into a previous-enable bit and clears the global enable. An interrupt-return strobe copies the saved value back.

Read data is combinational from the registered state and is valid while the read strobe is high. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `ctl_status_reg`

## Requirements
- R1: After reset the readback word holds zero in bits 15-0, except bit 8. Bit 8 and bits 31-16 follow their inputs. `gieOut`, `pgmCacheMode`, `dataCacheMode` and `pwrDownCtl` are all zero.
- R2: Bits 31-24 read back `cpuIdIn` and bits 23-16 read back `revIdIn`. Software writes to these bits have no effect.
- R3: Bit 8 reads back `endianPin` (1 little endian, 0 big endian). Software writes to bit 8 have no effect.
- R4: A write stores bits 15-10 and drives them on `pwrDownCtl`. Bits 15-10 of the readback are always zero.
- R5: A write stores bits 7-5 as the program cache mode and bits 4-2 as the data cache mode. Both read back in place and appear on `pgmCacheMode` and `dataCacheMode`.
- R6: A lane reporting saturation with its condition true in the cycle before clock edge E sets bit 9. The bit is still 0 after edge E and reads 1 after edge E+1.
- R7: A saturation report whose condition input is 0 leaves bit 9 unchanged.
- R8: A write with bit 9 = 1 clears the saturation flag at that edge. A write with bit 9 = 0 leaves it unchanged. No write can set it.
- R9: When a pending saturation set and a software clear land on the same edge, the flag ends at 1.
- R10: An interrupt-entry strobe copies the global enable (bit 0) into the previous enable (bit 1) and clears bit 0 at the same edge.
- R11: An interrupt-return strobe without an entry strobe copies bit 1 into bit 0. Bit 1 is kept.
- R12: When an interrupt strobe and a software write fall in the same cycle, the strobe decides bits 1-0 and the write still updates the other writable fields.
- R13: While the read strobe is low, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swRead | input | 1 | Software read strobe |
| swWrite | input | 1 | Software write strobe |
| swWdata | input | 32 | Software write data |
| rdData | output | 32 | Readback word, zero when not reading |
| satValid | input | NUM_UNITS | Per-lane saturation report |
| satCond | input | NUM_UNITS | Per-lane condition result of the reporting instruction |
| intTake | input | 1 | Interrupt-entry strobe |
| intReturn | input | 1 | Interrupt-return strobe |
| cpuIdIn | input | 8 | Constant processor identifier |
| revIdIn | input | 8 | Constant silicon revision |
| endianPin | input | 1 | Device endian setting |
| gieOut | output | 1 | Global interrupt enable |
| pgmCacheMode | output | 3 | Program cache mode |
| dataCacheMode | output | 3 | Data cache mode |
| pwrDownCtl | output | 6 | Stored power-down request |

## Verification
The bench builds the block with NUM_UNITS = 3. This keeps the lane count small enough that reports arrive on the middle lane and on a lane whose condition is false, so a mistake in how the lanes combine shows up. The identifier is set to 02h and the revision to 1Ah, so the constant fields carry patterns distinct from any written data. The endian pin is toggled in place to show the bit tracking the pin.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int ID_LSB    = 24;
  localparam int REV_LSB   = 16;
  localparam int PWRD_LSB  = 10;
  localparam int PWRD_W    = 6;
  localparam int SAT_BIT   = 9;
  localparam int END_BIT   = 8;
  localparam int PCC_LSB   = 5;
  localparam int DCC_LSB   = 2;
  localparam int MODE_W    = 3;
  localparam int PGIE_BIT  = 1;
  localparam int GIE_BIT   = 0;
  localparam int WORD_W    = 32;
  localparam int ID_W      = 8;

  typedef struct packed {
    logic cfgWr;
    logic satClr;
    logic satHit;
    logic irqEnter;
    logic irqExit;
  } csr_strobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 swWrite,
  input  logic                 satClrBit,
  input  logic [NUM_UNITS-1:0] satValid,
  input  logic [NUM_UNITS-1:0] satCond,
  input  logic                 intTake,
  input  logic                 intReturn,
  output csr_strobe_t          strb
);
  logic [NUM_UNITS-1:0] laneHit;

  genvar u;
  generate
    for (u = 0; u < NUM_UNITS; u++) begin : g_lane
      assign laneHit[u] = satValid[u] & satCond[u];
    end
  endgenerate

  always_comb begin
    strb.cfgWr    = swWrite;
    strb.satClr   = swWrite & satClrBit;
    strb.satHit   = |laneHit;
    strb.irqEnter = intTake;
    strb.irqExit  = intReturn & ~intTake;
  end
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strb,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [ID_W-1:0]   cpuIdIn,
  input  logic [ID_W-1:0]   revIdIn,
  input  logic              endianPin,
  output logic [WORD_W-1:0] rdWord,
  output logic              satFlag,
  output logic              pgieBit,
  output logic              gieBit,
  output logic [MODE_W-1:0] pccQ,
  output logic [MODE_W-1:0] dccQ,
  output logic [PWRD_W-1:0] pwrdQ
);
  logic satPendQ;
  logic unusedWr;

  assign unusedWr = ^{wrWord[WORD_W-1:PWRD_LSB+PWRD_W], wrWord[SAT_BIT], wrWord[END_BIT]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrdQ <= '0;
      pccQ  <= '0;
      dccQ  <= '0;
    end else if (strb.cfgWr) begin
      pwrdQ <= wrWord[PWRD_LSB +: PWRD_W];
      pccQ  <= wrWord[PCC_LSB +: MODE_W];
      dccQ  <= wrWord[DCC_LSB +: MODE_W];
    end
  end

  // one delay slot: report is captured, then lands in the flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      satPendQ <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      satPendQ <= strb.satHit;
      if (satPendQ)         satFlag <= 1'b1;
      else if (strb.satClr) satFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieBit  <= 1'b0;
      pgieBit <= 1'b0;
    end else if (strb.irqEnter) begin
      pgieBit <= gieBit;
      gieBit  <= 1'b0;
    end else if (strb.irqExit) begin
      gieBit  <= pgieBit;
    end else if (strb.cfgWr) begin
      gieBit  <= wrWord[GIE_BIT];
      pgieBit <= wrWord[PGIE_BIT];
    end
  end

  always_comb begin
    rdWord = '0;
    rdWord[ID_LSB +: ID_W]    = cpuIdIn;
    rdWord[REV_LSB +: ID_W]   = revIdIn;
    rdWord[SAT_BIT]           = satFlag;
    rdWord[END_BIT]           = endianPin;
    rdWord[PCC_LSB +: MODE_W] = pccQ;
    rdWord[DCC_LSB +: MODE_W] = dccQ;
    rdWord[PGIE_BIT]          = pgieBit;
    rdWord[GIE_BIT]           = gieBit;
  end
endmodule

// File: rtl/ctl_status_reg.sv
module ctl_status_reg
  import csr_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swRead,
  input  logic                 swWrite,
  input  logic [31:0]          swWdata,
  output logic [31:0]          rdData,
  input  logic [NUM_UNITS-1:0] satValid,
  input  logic [NUM_UNITS-1:0] satCond,
  input  logic                 intTake,
  input  logic                 intReturn,
  input  logic [7:0]           cpuIdIn,
  input  logic [7:0]           revIdIn,
  input  logic                 endianPin,
  output logic                 gieOut,
  output logic [2:0]           pgmCacheMode,
  output logic [2:0]           dataCacheMode,
  output logic [5:0]           pwrDownCtl
);
  csr_strobe_t       strb;
  logic [WORD_W-1:0] rdWord;
  logic              satFlag;
  logic              pgieBit;

  csr_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
    .swWrite   (swWrite),
    .satClrBit (swWdata[SAT_BIT]),
    .satValid  (satValid),
    .satCond   (satCond),
    .intTake   (intTake),
    .intReturn (intReturn),
    .strb      (strb)
  );

  csr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrWord    (swWdata),
    .cpuIdIn   (cpuIdIn),
    .revIdIn   (revIdIn),
    .endianPin (endianPin),
    .rdWord    (rdWord),
    .satFlag   (satFlag),
    .pgieBit   (pgieBit),
    .gieBit    (gieOut),
    .pccQ      (pgmCacheMode),
    .dccQ      (dataCacheMode),
    .pwrdQ     (pwrDownCtl)
  );

  assign rdData = swRead ? rdWord : '0;
endmodule

// File: rtl/csr_chk.sv
module csr_chk #(
  parameter int NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 swRead,
  input logic                 swWrite,
  input logic [31:0]          swWdata,
  input logic [31:0]          rdData,
  input logic [NUM_UNITS-1:0] satValid,
  input logic [NUM_UNITS-1:0] satCond,
  input logic                 intTake,
  input logic                 intReturn,
  input logic                 gieOut,
  input logic                 satFlag,
  input logic                 pgieBit
);
  logic hit;
  assign hit = |(satValid & satCond);

  // R6
  sat_set_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ##2 satFlag);

  // R8
  sat_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> $past(hit, 2));

  // R8
  sat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swWrite && swWdata[9] && !$past(hit)) |=> !satFlag);

  // R10
  gie_clear_on_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    intTake |=> !gieOut);

  // R10
  pgie_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    intTake |=> pgieBit == $past(gieOut));

  // R11
  gie_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReturn && !intTake) |=> gieOut == $past(pgieBit));

  // R13
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swRead |-> rdData == 32'd0);

  // R4
  pwrd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[15:10] == 6'd0);
endmodule

bind ctl_status_reg csr_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swRead    (swRead),
  .swWrite   (swWrite),
  .swWdata   (swWdata),
  .rdData    (rdData),
  .satValid  (satValid),
  .satCond   (satCond),
  .intTake   (intTake),
  .intReturn (intReturn),
  .gieOut    (gieOut),
  .satFlag   (satFlag),
  .pgieBit   (pgieBit)
);

// File: tb/sim_ctl_status_reg.sv
module sim_ctl_status_reg;
  localparam int NU = 3;
  localparam logic [31:0] BASE = 32'h021A_0100;

  localparam logic [31:0] VEC_W [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_00A5, 32'h1234_FE5A};
  localparam logic [31:0] VEC_R [4] = '{32'h021A_01FF, 32'h021A_0100, 32'h021A_01A5, 32'h021A_015A};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swRead = 1'b0, swWrite = 1'b0;
  logic [31:0] swWdata = '0;
  logic [31:0] rdData;
  logic [NU-1:0] satValid = '0, satCond = '0;
  logic intTake = 1'b0, intReturn = 1'b0;
  logic [7:0] cpuIdIn = 8'h02, revIdIn = 8'h1A;
  logic endianPin = 1'b1;
  logic gieOut;
  logic [2:0] pgmCacheMode, dataCacheMode;
  logic [5:0] pwrDownCtl;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ctl_status_reg #(.NUM_UNITS(NU)) u0 (
    .clk(clk), .rstN(rstN), .swRead(swRead), .swWrite(swWrite), .swWdata(swWdata),
    .rdData(rdData), .satValid(satValid), .satCond(satCond), .intTake(intTake),
    .intReturn(intReturn), .cpuIdIn(cpuIdIn), .revIdIn(revIdIn), .endianPin(endianPin),
    .gieOut(gieOut), .pgmCacheMode(pgmCacheMode), .dataCacheMode(dataCacheMode),
    .pwrDownCtl(pwrDownCtl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    swWrite = 1'b1;
    swWdata = d;
    step();
    swWrite = 1'b0;
    swWdata = '0;
  endtask

  task automatic rd(input string req, input logic [31:0] exp);
    swRead = 1'b1;
    #1;
    check(req, rdData, exp);
    swRead = 1'b0;
  endtask

  task automatic report(input logic [NU-1:0] v, input logic [NU-1:0] c);
    satValid = v;
    satCond = c;
    step();
    satValid = '0;
    satCond = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    rstN = 1'b1;
    // R1 reset state
    rd("R1 reset word", BASE);
    check("R1 reset gie", {31'd0, gieOut}, 32'd0);
    check("R1 reset modes", {26'd0, pgmCacheMode, dataCacheMode}, 32'd0);
    check("R1 reset pwrd", {26'd0, pwrDownCtl}, 32'd0);

    // table: R2 R3 R4 R5 field access
    for (int i = 0; i < 4; i++) begin
      wr(VEC_W[i]);
      rd("R2 R3 R4 R5 readback", VEC_R[i]);
      check("R4 pwrd output", {26'd0, pwrDownCtl}, {26'd0, VEC_W[i][15:10]});
      check("R5 cache outputs", {26'd0, pgmCacheMode, dataCacheMode},
            {26'd0, VEC_W[i][7:5], VEC_W[i][4:2]});
    end

    // R3 endian tracks the pin
    endianPin = 1'b0;
    rd("R3 endian low", 32'h021A_005A);
    endianPin = 1'b1;
    // R2 identity follows inputs
    cpuIdIn = 8'h00;
    rd("R2 id input", 32'h001A_015A);
    cpuIdIn = 8'h02;
    wr(32'h0);

    // R6 one delay slot
    report(3'b010, 3'b010);
    rd("R6 not yet set", BASE);
    step();
    rd("R6 set after slot", BASE | 32'h200);

    // R8 writing bit9=0 keeps, bit9=1 clears
    wr(32'h0);
    rd("R8 write zero keeps", BASE | 32'h200);
    wr(32'h200);
    rd("R8 write one clears", BASE);

    // R7 condition false ignored
    report(3'b101, 3'b010);
    step();
    step();
    rd("R7 cond false", BASE);

    // R9 set beats same-edge clear
    report(3'b001, 3'b001);
    wr(32'h200);
    rd("R9 set wins", BASE | 32'h200);
    wr(32'h200);
    rd("R9 later clear", BASE);

    // R10 entry saves and clears
    wr(32'h1);
    intTake = 1'b1;
    step();
    intTake = 1'b0;
    rd("R10 entry", BASE | 32'h2);
    check("R10 gie out", {31'd0, gieOut}, 32'd0);

    // R11 return restores
    intReturn = 1'b1;
    step();
    intReturn = 1'b0;
    rd("R11 return", BASE | 32'h3);
    check("R11 gie out", {31'd0, gieOut}, 32'd1);

    // R12 entry beats write on bits 1-0, other fields still written
    intTake = 1'b1;
    wr(32'h0000_00E0);
    intTake = 1'b0;
    rd("R12 entry over write", BASE | 32'hE2);

    // R13 idle read is zero
    #1;
    check("R13 idle read", rdData, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule